// File: doc/BRIEF.md
# Guarded Nonvolatile Area Access Sequencer

This block sits on the host side of a timekeeping device and carries out one safe transfer to or from the device's nonvolatile configuration area. It is the only master on a byte-wide register bus. On that bus it raises a request with a write flag, an address and write data. The device completes each access with a one-cycle acknowledge, and read data is valid in that same cycle. The host hands over a command: direction, start address and byte count. When the sequence ends, the block reports a one-cycle completion pulse together with a two-bit result code.

Around the data movement the block runs a protective sequence. First it checks the two supply-low flags in the device status. If either flag is set, it clears them once and tests them again, and it gives up if they persist. It then turns off the device's background refresh with a read-modify-write of the control register and waits for the memory busy flag to drop. Next it moves the bytes. On writes it leaves alone any byte that already holds the requested value, and it waits for the memory to become idle after every byte. At the end it turns refresh back on, again with a read-modify-write. The wait between polls is a parameterised count of clock cycles.

Top module: `nvm_access_seq`

## Requirements
- R1: A command whose start address is above 0x3F, or whose start address plus byte count exceeds 0x40, ends with result code 3 and a done pulse in the cycle after it is accepted. It issues no bus access.
- R2: The status register sits at bus address 0x03, with the supply-low flags at bits 2 and 3. If either flag reads as set, the block writes the status back with both flags cleared, waits one delay period and reads the status again. If a flag is still set, the block ends with result code 1 without any access to another address.
- R3: If the flags are clear on that second status read, the sequence continues as if they had never been set.
- R4: Before any data byte is touched, the block reads the control register at address 0x00 and writes it back with bit 3 (refresh enable) cleared and every other bit unchanged.
- R5: Every sequence that got past the supply check ends by reading the control register again and writing it back with bit 3 set and all other bits as read. This also holds on a busy timeout.
- R6: Status bit 7 means the memory is busy. The block reads the status at most POLL_MAX times, with one delay period after each busy reading. If the flag is still set on the last read, it restores refresh and ends with result code 2.
- R7: On a write command, each byte is first read from its address. It is written only if it differs from the requested value. A busy wait follows every byte, whether or not it was written.
- R8: On a read command, the bytes are read at ascending addresses. Each byte is presented on rd_data with a one-cycle rd_valid pulse, in order.
- R9: cmd_ready is high only when the block is idle. done is a single-cycle pulse, and err holds the result code while done is high (0 for success). A byte count of zero runs only the entry and exit steps.
- R10: Once bus_req is raised, it stays high with an unchanged address until bus_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | 8 | Start address in the nonvolatile area |
| cmd_len | input | LEN_W | Byte count |
| wr_data | input | 8 | Value requested for the byte at xfer_idx |
| xfer_idx | output | LEN_W | Index of the byte being handled |
| rd_valid | output | 1 | Read byte present on rd_data |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 2 | Result: 0 ok, 1 low supply, 2 timeout, 3 bad range |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 8 | Bus register address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
Two cases are the hardest to reach from the ports. One is the low-supply path where the flag clears on the retry. The other is the busy timeout that must still restore refresh. Neither happens unless the device on the bus misbehaves in a specific way. The bench device model therefore holds configurable state: supply-low flags that either clear on write-back or stay set, and busy counters that keep status bit 7 set for a chosen number of status reads at entry and after each stored byte. A count of 150 at entry drives the block through all POLL_MAX polls to the timeout exit.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    localparam int AW = 8;
    localparam int DW = 8;

    localparam logic [AW-1:0] SR_ADDR  = 8'h03;
    localparam logic [AW-1:0] CTL_ADDR = 8'h00;

    localparam int LOW_A_BIT   = 2;
    localparam int LOW_B_BIT   = 3;
    localparam int BUSY_BIT    = 7;
    localparam int REFRESH_BIT = 3;

    localparam logic [DW-1:0] LOW_MASK     = (DW'(1) << LOW_A_BIT) | (DW'(1) << LOW_B_BIT);
    localparam logic [DW-1:0] REFRESH_MASK = DW'(1) << REFRESH_BIT;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_LOWSUP  = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_RANGE   = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK_SR,
        ST_CLR_LOW,
        ST_LOW_WAIT,
        ST_RECHK_SR,
        ST_CTL_RD,
        ST_CTL_WR,
        ST_POLL_RD,
        ST_POLL_WAIT,
        ST_XFER_RD,
        ST_XFER_WR,
        ST_EXIT_RD,
        ST_EXIT_WR,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_t;

    function automatic logic has_low(input logic [DW-1:0] s);
        return |(s & LOW_MASK);
    endfunction

endpackage

// File: rtl/nvs_delay.sv
module nvs_delay #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    delay_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(CYCLES));

endmodule

// File: rtl/nvs_range.sv
module nvs_range #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 7,
    parameter int LIMIT  = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              ok
);
    localparam int SW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

    logic [SW-1:0] end_sum;

    assign end_sum = SW'(addr) + SW'(len);
    assign ok      = (SW'(addr) < SW'(LIMIT)) && (end_sum <= SW'(LIMIT));

endmodule

// File: rtl/nvm_access_seq.sv
module nvm_access_seq
    import nvs_pkg::*;
#(
    parameter int LEN_W        = 7,
    parameter int AREA_SIZE    = 64,
    parameter int POLL_MAX     = 100,
    parameter int DELAY_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_write,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [DW-1:0]    wr_data,
    output logic [LEN_W-1:0] xfer_idx,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic [1:0]       err,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ack
);
    localparam int PW = $clog2(POLL_MAX + 1);

    state_e           st_q;
    err_e             err_q;
    logic             wr_q;
    logic             entry_q;
    logic [AW-1:0]    base_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic [DW-1:0]    sr_q;
    logic [DW-1:0]    ctl_q;
    logic [PW-1:0]    poll_q;
    logic             rdv_q;
    logic [DW-1:0]    rdd_q;

    bus_t             bus_d;
    logic             acc_done;
    logic             dly_expired;
    logic             range_ok;
    logic             last_byte;
    logic [AW-1:0]    cur_addr;

    nvs_delay #(.CYCLES(DELAY_CYCLES)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .run     ((st_q == ST_LOW_WAIT) || (st_q == ST_POLL_WAIT)),
        .expired (dly_expired)
    );

    nvs_range #(.ADDR_W(AW), .LEN_W(LEN_W), .LIMIT(AREA_SIZE)) u_range (
        .addr (cmd_addr),
        .len  (cmd_len),
        .ok   (range_ok)
    );

    assign cur_addr  = base_q + AW'(idx_q);
    assign last_byte = ({1'b0, idx_q} + (LEN_W+1)'(1)) == {1'b0, len_q};
    assign acc_done  = bus_req && bus_ack;

    always_comb begin
        bus_d = '0;
        unique case (st_q)
            ST_CHK_SR, ST_RECHK_SR, ST_POLL_RD:
                bus_d = '{req: 1'b1, we: 1'b0, addr: SR_ADDR, data: '0};
            ST_CLR_LOW:
                bus_d = '{req: 1'b1, we: 1'b1, addr: SR_ADDR, data: sr_q & ~LOW_MASK};
            ST_CTL_RD, ST_EXIT_RD:
                bus_d = '{req: 1'b1, we: 1'b0, addr: CTL_ADDR, data: '0};
            ST_CTL_WR:
                bus_d = '{req: 1'b1, we: 1'b1, addr: CTL_ADDR, data: ctl_q & ~REFRESH_MASK};
            ST_EXIT_WR:
                bus_d = '{req: 1'b1, we: 1'b1, addr: CTL_ADDR, data: ctl_q | REFRESH_MASK};
            ST_XFER_RD:
                bus_d = '{req: 1'b1, we: 1'b0, addr: cur_addr, data: '0};
            ST_XFER_WR:
                bus_d = '{req: 1'b1, we: 1'b1, addr: cur_addr, data: wr_data};
            default:
                bus_d = '0;
        endcase
    end

    assign bus_req   = bus_d.req;
    assign bus_we    = bus_d.we;
    assign bus_addr  = bus_d.addr;
    assign bus_wdata = bus_d.data;

    assign cmd_ready = (st_q == ST_IDLE);
    assign done      = (st_q == ST_DONE);
    assign err       = err_q;
    assign xfer_idx  = idx_q;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            err_q   <= ERR_NONE;
            wr_q    <= 1'b0;
            entry_q <= 1'b0;
            base_q  <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            sr_q    <= '0;
            ctl_q   <= '0;
            poll_q  <= '0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
        end else begin
            rdv_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        wr_q   <= cmd_write;
                        base_q <= cmd_addr;
                        len_q  <= cmd_len;
                        idx_q  <= '0;
                        if (!range_ok) begin
                            err_q <= ERR_RANGE;
                            st_q  <= ST_DONE;
                        end else begin
                            err_q <= ERR_NONE;
                            st_q  <= ST_CHK_SR;
                        end
                    end
                end
                ST_CHK_SR: begin
                    if (acc_done) begin
                        sr_q <= bus_rdata;
                        st_q <= has_low(bus_rdata) ? ST_CLR_LOW : ST_CTL_RD;
                    end
                end
                ST_CLR_LOW: begin
                    if (acc_done) st_q <= ST_LOW_WAIT;
                end
                ST_LOW_WAIT: begin
                    if (dly_expired) st_q <= ST_RECHK_SR;
                end
                ST_RECHK_SR: begin
                    if (acc_done) begin
                        if (has_low(bus_rdata)) begin
                            err_q <= ERR_LOWSUP;
                            st_q  <= ST_DONE;
                        end else begin
                            st_q  <= ST_CTL_RD;
                        end
                    end
                end
                ST_CTL_RD: begin
                    if (acc_done) begin
                        ctl_q <= bus_rdata;
                        st_q  <= ST_CTL_WR;
                    end
                end
                ST_CTL_WR: begin
                    if (acc_done) begin
                        poll_q  <= '0;
                        entry_q <= 1'b1;
                        st_q    <= ST_POLL_RD;
                    end
                end
                ST_POLL_RD: begin
                    if (acc_done) begin
                        if (bus_rdata[BUSY_BIT]) begin
                            if (poll_q == PW'(POLL_MAX - 1)) begin
                                err_q <= ERR_TIMEOUT;
                                st_q  <= ST_EXIT_RD;
                            end else begin
                                poll_q <= poll_q + 1'b1;
                                st_q   <= ST_POLL_WAIT;
                            end
                        end else if (entry_q) begin
                            entry_q <= 1'b0;
                            st_q    <= (len_q == '0) ? ST_EXIT_RD : ST_XFER_RD;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= last_byte ? ST_EXIT_RD : ST_XFER_RD;
                        end
                    end
                end
                ST_POLL_WAIT: begin
                    if (dly_expired) st_q <= ST_POLL_RD;
                end
                ST_XFER_RD: begin
                    if (acc_done) begin
                        if (wr_q) begin
                            if (bus_rdata != wr_data) begin
                                st_q <= ST_XFER_WR;
                            end else begin
                                poll_q <= '0;
                                st_q   <= ST_POLL_RD;
                            end
                        end else begin
                            rdv_q <= 1'b1;
                            rdd_q <= bus_rdata;
                            idx_q <= idx_q + 1'b1;
                            if (last_byte) st_q <= ST_EXIT_RD;
                        end
                    end
                end
                ST_XFER_WR: begin
                    if (acc_done) begin
                        poll_q <= '0;
                        st_q   <= ST_POLL_RD;
                    end
                end
                ST_EXIT_RD: begin
                    if (acc_done) begin
                        ctl_q <= bus_rdata;
                        st_q  <= ST_EXIT_WR;
                    end
                end
                ST_EXIT_WR: begin
                    if (acc_done) st_q <= ST_DONE;
                end
                ST_DONE: begin
                    st_q <= ST_IDLE;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Observation state for the properties below: what the bus has seen since accept.
    logic any_acc_q;
    logic other_acc_q;
    logic refresh_off_q;

    always_ff @(posedge clk) begin
        if (rst || (cmd_ready && cmd_valid)) begin
            any_acc_q     <= 1'b0;
            other_acc_q   <= 1'b0;
            refresh_off_q <= 1'b0;
        end else if (acc_done) begin
            any_acc_q <= 1'b1;
            if (bus_addr != SR_ADDR) other_acc_q <= 1'b1;
            if (bus_we && (bus_addr == CTL_ADDR)) refresh_off_q <= !bus_wdata[REFRESH_BIT];
        end
    end

    // R1
    range_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (err == 2'd3)) |-> !any_acc_q);

    // R2
    lowsup_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (err == 2'd1)) |-> !other_acc_q);

    // R4
    refresh_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && ((st_q == ST_XFER_RD) || (st_q == ST_XFER_WR))) |-> refresh_off_q);

    // R5
    refresh_back_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !refresh_off_q);

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        poll_q < PW'(POLL_MAX));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && cmd_ready));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && cmd_valid) |=> !cmd_ready);

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

endmodule

// File: tb/nvm_access_seq_bench.sv
`timescale 1ns/1ps
module nvm_access_seq_bench;
    import nvs_pkg::*;

    localparam int LEN_W = 7;
    localparam int POLL  = 100;
    localparam int DLY   = 6;
    localparam int LAT   = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst;
    logic             cmd_valid, cmd_ready, cmd_write;
    logic [7:0]       cmd_addr;
    logic [LEN_W-1:0] cmd_len;
    logic [7:0]       wr_data;
    logic [LEN_W-1:0] xfer_idx;
    logic             rd_valid;
    logic [7:0]       rd_data;
    logic             done;
    logic [1:0]       err;
    logic             bus_req, bus_we, bus_ack;
    logic [7:0]       bus_addr, bus_wdata, bus_rdata;

    nvm_access_seq #(.LEN_W(LEN_W), .AREA_SIZE(64), .POLL_MAX(POLL), .DELAY_CYCLES(DLY)) u_nvm_access_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_data(wr_data), .xfer_idx(xfer_idx), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err(err), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // configuration of the device model, written by the stimulus
    logic       cfg_load = 1'b0;
    int         cfg_busy = 0;
    int         cfg_bpw  = 0;
    logic [1:0] cfg_low  = 2'b00;
    logic       cfg_sticky = 1'b0;
    logic [7:0] cfg_ctl  = 8'h00;
    logic [7:0] wbuf [128];

    // device model
    logic [7:0] dmem [256];
    logic [7:0] ctl_reg;
    logic [1:0] low_bits;
    int         busy_left;
    int         lat;

    assign wr_data   = wbuf[xfer_idx];
    assign bus_rdata = (bus_addr == 8'h03) ? (8'h20 | ((busy_left > 0) ? 8'h80 : 8'h00) | {4'b0, low_bits, 2'b00}) :
                       (bus_addr == 8'h00) ? ctl_reg : dmem[bus_addr];

    always @(posedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0; lat <= 0; busy_left <= 0; low_bits <= 2'b00; ctl_reg <= 8'h00;
            for (int i = 0; i < 256; i++) dmem[i] <= 8'(i * 5 + 1);
        end else if (cfg_load) begin
            busy_left <= cfg_busy; low_bits <= cfg_low; ctl_reg <= cfg_ctl;
        end else if (bus_ack) begin
            bus_ack <= 1'b0; lat <= 0;
            if (bus_we) begin
                if (bus_addr == 8'h03) begin
                    if (!cfg_sticky) low_bits <= bus_wdata[3:2];
                end else if (bus_addr == 8'h00) ctl_reg <= bus_wdata;
                else begin dmem[bus_addr] <= bus_wdata; busy_left <= cfg_bpw; end
            end else if (bus_addr == 8'h03 && busy_left > 0) busy_left <= busy_left - 1;
        end else if (bus_req) begin
            if (lat == LAT) bus_ack <= 1'b1; else lat <= lat + 1;
        end
    end

    // reference model state
    logic [7:0]  mm [256];
    logic [16:0] exp_q [$];
    logic [7:0]  exp_rd [$];
    logic [1:0]  exp_err;
    int tests = 0, fails = 0;
    bit wd_hit = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sr_next(inout int bl, input logic [1:0] low, output logic [7:0] v);
        v = 8'h20 | ((bl > 0) ? 8'h80 : 8'h00) | {4'b0, low, 2'b00};
        if (bl > 0) bl--;
        exp_q.push_back({1'b0, 8'h03, 8'h00});
    endtask

    task automatic poll(inout int bl, input logic [1:0] low, output bit ok);
        logic [7:0] v;
        ok = 1'b0;
        for (int i = 0; i < POLL; i++) begin
            sr_next(bl, low, v);
            if (!v[7]) begin ok = 1'b1; return; end
        end
    endtask

    task automatic build(input logic w, input logic [7:0] a, input int n);
        int bl; logic [1:0] low; logic [7:0] v; bit ok;
        bl = cfg_busy; low = cfg_low;
        exp_q.delete(); exp_rd.delete(); exp_err = 2'd0;
        if (a > 8'h3F || int'(a) + n > 64) begin exp_err = 2'd3; return; end
        sr_next(bl, low, v);
        if (low != 2'b00) begin
            exp_q.push_back({1'b1, 8'h03, v & 8'hF3});
            if (!cfg_sticky) low = 2'b00;
            sr_next(bl, low, v);
            if (low != 2'b00) begin exp_err = 2'd1; return; end
        end
        exp_q.push_back({1'b0, 8'h00, 8'h00});
        exp_q.push_back({1'b1, 8'h00, cfg_ctl & 8'hF7});
        poll(bl, low, ok);
        for (int i = 0; ok && i < n; i++) begin
            exp_q.push_back({1'b0, 8'(a + i), 8'h00});
            if (!w) exp_rd.push_back(mm[8'(a + i)]);
            else begin
                if (mm[8'(a + i)] != wbuf[i]) begin
                    exp_q.push_back({1'b1, 8'(a + i), wbuf[i]});
                    mm[8'(a + i)] = wbuf[i];
                    bl = cfg_bpw;
                end
                poll(bl, low, ok);
            end
        end
        if (!ok) exp_err = 2'd2;
        exp_q.push_back({1'b0, 8'h00, 8'h00});
        exp_q.push_back({1'b1, 8'h00, cfg_ctl | 8'h08});
    endtask

    task automatic run_cmd(input logic w, input logic [7:0] a, input int n, input string tag);
        logic [16:0] e; logic [7:0] r;
        int ready_bad = 0, hold_bad = 0;
        logic prev_hold = 1'b0; logic [7:0] prev_addr = 8'h00;
        build(w, a, n);
        @(negedge clk); cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
        cmd_write = w; cmd_addr = a; cmd_len = LEN_W'(n); cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        while (!done && !wd_hit) begin
            if (cmd_ready) ready_bad++;
            if (prev_hold && (!bus_req || bus_addr != prev_addr)) hold_bad++;
            prev_hold = bus_req && !bus_ack; prev_addr = bus_addr;
            if (bus_req && bus_ack) begin
                if (exp_q.size() == 0) check(1'b0, tag, "unexpected bus access", int'({bus_we, bus_addr, bus_wdata}), 0);
                else begin
                    e = exp_q.pop_front();
                    check(bus_we == e[16] && bus_addr == e[15:8] && (!bus_we || bus_wdata == e[7:0]),
                          tag, "bus access we/addr/data", int'({bus_we, bus_addr, bus_wdata}), int'(e));
                end
            end
            if (rd_valid) begin
                if (exp_rd.size() == 0) check(1'b0, "R8", "unexpected read byte", int'(rd_data), 0);
                else begin r = exp_rd.pop_front(); check(rd_data == r, "R8", "read byte", int'(rd_data), int'(r)); end
            end
            @(negedge clk);
        end
        check(done, tag, "done reached", int'(done), 1);
        check(err == exp_err, tag, "result code", int'(err), int'(exp_err));
        check(exp_q.size() == 0, tag, "bus accesses missing", exp_q.size(), 0);
        check(exp_rd.size() == 0, "R8", "read bytes missing", exp_rd.size(), 0);
        check(ready_bad == 0, "R9", "cmd_ready high while running", ready_bad, 0);
        check(hold_bad == 0, "R10", "request dropped or address moved before ack", hold_bad, 0);
        @(negedge clk);
        check(!done && cmd_ready, "R9", "done single cycle then ready", int'({done, cmd_ready}), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        wd_hit = 1;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = 8'h00; cmd_len = '0;
        for (int i = 0; i < 128; i++) wbuf[i] = 8'h00;
        for (int i = 0; i < 256; i++) mm[i] = 8'(i * 5 + 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready && !done && !bus_req && !rd_valid, "R9", "reset state", int'({cmd_ready, done, bus_req, rd_valid}), 8);

        // R1: start above area, then end past area, then exact fit at the top
        run_cmd(1'b0, 8'h40, 1, "R1");
        run_cmd(1'b0, 8'h3E, 3, "R1");
        run_cmd(1'b0, 8'h3E, 2, "R1");

        // R8 / R4 / R5 / R6: read with entry busy wait, refresh bit initially set
        cfg_ctl = 8'hA9; cfg_busy = 2;
        run_cmd(1'b0, 8'h10, 5, "R4");
        check(ctl_reg == 8'hA9, "R5", "control restored", int'(ctl_reg), 8'hA9);

        // R7: write, two bytes already equal, busy after each stored byte
        cfg_ctl = 8'h54; cfg_busy = 0; cfg_bpw = 3;
        wbuf[0] = mm[8'h20]; wbuf[1] = 8'hC3; wbuf[2] = mm[8'h22]; wbuf[3] = 8'h3C;
        run_cmd(1'b1, 8'h20, 4, "R7");
        check(ctl_reg == 8'h5C, "R5", "refresh set, others kept", int'(ctl_reg), 8'h5C);
        check(dmem[8'h21] == 8'hC3 && dmem[8'h23] == 8'h3C, "R7", "stored bytes", int'({dmem[8'h21], dmem[8'h23]}), 16'hC33C);
        run_cmd(1'b0, 8'h20, 4, "R8");

        // R3: transient low flag
        cfg_bpw = 0; cfg_ctl = 8'h00; cfg_low = 2'b01; cfg_sticky = 1'b0;
        run_cmd(1'b0, 8'h30, 2, "R3");

        // R2: persistent low flag, write must not happen
        cfg_low = 2'b10; cfg_sticky = 1'b1; cfg_ctl = 8'h33;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        begin
            logic [7:0] keep0, keep1;
            keep0 = dmem[8'h30]; keep1 = dmem[8'h31];
            run_cmd(1'b1, 8'h30, 2, "R2");
            check(dmem[8'h30] == keep0 && dmem[8'h31] == keep1, "R2", "area untouched", int'({dmem[8'h30], dmem[8'h31]}), int'({keep0, keep1}));
            check(ctl_reg == 8'h33, "R2", "control untouched", int'(ctl_reg), 8'h33);
        end

        // R6: busy never clears within the poll budget
        cfg_low = 2'b00; cfg_sticky = 1'b0; cfg_ctl = 8'hF0; cfg_busy = 150;
        run_cmd(1'b0, 8'h08, 3, "R6");
        check(ctl_reg == 8'hF8, "R6", "refresh restored after timeout", int'(ctl_reg), 8'hF8);

        // R9: zero length runs entry and exit only
        cfg_busy = 0; cfg_ctl = 8'h08;
        run_cmd(1'b0, 8'h08, 0, "R9");

        if (wd_hit) begin
            fails++;
            $display("FAIL watchdog: actual expired expected finished");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule